// File: doc/BRIEF.md
# Serial Transfer Start Sequencer

This block decides the moment at which a synchronous serial shifter begins moving a data word. A four-bit rule code selects what counts as a start condition. The choices are free-running, a start pulse from the opposite direction, a compare-match pulse, a low or high level on the frame-sync line, or a falling, rising or any change on that line. After it finds a condition, the block counts a programmable number of bit clocks. It then raises a one-cycle start strobe towards the shifter and holds off further starts until the shifter reports the end of the transfer.

The block also has separate enable, disable and soft-reset commands. It generates a periodic frame pulse whose spacing comes from an 8-bit period field. Everything runs on the bit clock with a synchronous active-high reset.

The sequencer has four named states:
- OFF: disabled.
- WAIT: armed and watching for a condition.
- DELAY: counting the start delay.
- XFER: transfer in progress.

Its transitions are:
- OFF to WAIT on enable.
- WAIT to XFER on a condition when the delay is 0.
- WAIT to DELAY on a condition when the delay is not 0.
- DELAY to XFER when the count runs out.
- XFER to WAIT on end-of-transfer.
- Any state to OFF on disable or soft reset.

Top module: `xfer_start_ctrl`

## Requirements
- R1: `cmd_on` moves the block from idle to running after one clock edge. `cmd_off` returns it to idle after one edge. When `cmd_on` and `cmd_off` are both high in the same cycle, the block ends up idle. `running` reports the state.
- R2: `cmd_reset` returns the block to idle from any state, including during a pending start delay. The cancelled start produces no strobe.
- R3: Rule code 0 (free-running) starts a transfer on the first edge after the block is armed. It starts again on the first edge after the block rearms following `xfer_done`.
- R4: Rule code 1 starts on a high `peer_start` and code 8 starts on a high `cmp_hit`. Each of these rules ignores the other's pulse.
- R5: Rule code 2 starts while `fsync_in` is low and code 3 starts while it is high.
- R6: Each edge rule compares `fsync_in` with its value one edge earlier:
  - code 4 starts on a 1-to-0 change;
  - code 5 starts on a 0-to-1 change;
  - code 6 starts on either change;
  - code 7 also starts on either change.
  A change in the other direction does not start codes 4 and 5.
- R7: Rule codes 9 to 15 never start a transfer, whatever the inputs do.
- R8: If a condition is sampled at clock edge T and `start_delay` is D, `start_strobe` is high for exactly the one cycle after edge T+D. D ranges from 0 to 255.
- R9: A condition seen during DELAY or XFER is ignored and produces no extra strobe. XFER lasts until `xfer_done` is sampled high.
- R10: With `period_div` P not 0, `frame_pulse` is high for one cycle every 2×(P+1) cycles while running. The first pulse comes 2P+1 edges after the enabling edge. With P equal to 0 there are no pulses.
- R11: After reset, `running`, `busy`, `start_strobe` and `frame_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_on | input | 1 | Enable command |
| cmd_off | input | 1 | Disable command, wins over `cmd_on` |
| cmd_reset | input | 1 | Soft reset to idle |
| start_mode | input | 4 | Start rule code (0 to 8 valid) |
| start_delay | input | 8 | Bit clocks from the condition to the strobe |
| period_div | input | 8 | Frame pulse period field, 0 turns the pulse off |
| fsync_in | input | 1 | Frame-sync line |
| peer_start | input | 1 | Start pulse from the opposite direction |
| cmp_hit | input | 1 | Compare-match pulse |
| xfer_done | input | 1 | End of the current transfer |
| start_strobe | output | 1 | One-cycle start strobe to the shifter |
| frame_pulse | output | 1 | Periodic frame pulse |
| running | output | 1 | Block is enabled |
| busy | output | 1 | Delay counting or transfer in progress |

## Verification
Each start rule is armed with the frame-sync line held at the level that does not match the rule. The bench then applies the matching stimulus and measures the strobe latency against the programmed delay, from 0 up to 255. It also applies stimuli that look similar but must not start the rule: the opposite edge, the other pulse source, or an undefined code. These show that the rules are really distinct and not just triggered by any activity.

Directed runs cover several more cases:
- A free-running restart after end-of-transfer.
- A held trigger that overlaps the delay window, and a trigger that arrives during a transfer.
- A soft reset that cancels a pending delay.
- Simultaneous enable and disable.
- Three period settings, which separate the correct spacing from off-by-one counts.

// File: rtl/xfer_start_pkg.sv
package xfer_start_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_XFER  = 2'd3
    } seq_state_t;

    localparam logic [3:0] RULE_FREE    = 4'd0;
    localparam logic [3:0] RULE_PEER    = 4'd1;
    localparam logic [3:0] RULE_LOW     = 4'd2;
    localparam logic [3:0] RULE_HIGH    = 4'd3;
    localparam logic [3:0] RULE_FALL    = 4'd4;
    localparam logic [3:0] RULE_RISE    = 4'd5;
    localparam logic [3:0] RULE_CHANGE  = 4'd6;
    localparam logic [3:0] RULE_ANYEDGE = 4'd7;
    localparam logic [3:0] RULE_CMP     = 4'd8;

endpackage

// File: rtl/start_cond_sel.sv
module start_cond_sel
    import xfer_start_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rule,
    input  logic       fsync_in,
    input  logic       peer_start,
    input  logic       cmp_hit,
    output logic       cond
);

    logic fsync_q;

    always_ff @(posedge clk) begin
        if (rst) fsync_q <= 1'b0;
        else     fsync_q <= fsync_in;
    end

    always_comb begin
        case (rule)
            RULE_FREE:    cond = 1'b1;
            RULE_PEER:    cond = peer_start;
            RULE_LOW:     cond = ~fsync_in;
            RULE_HIGH:    cond = fsync_in;
            RULE_FALL:    cond = fsync_q & ~fsync_in;
            RULE_RISE:    cond = ~fsync_q & fsync_in;
            RULE_CHANGE:  cond = fsync_q ^ fsync_in;
            RULE_ANYEDGE: cond = fsync_q ^ fsync_in;
            RULE_CMP:     cond = cmp_hit;
            default:      cond = 1'b0;
        endcase
    end

    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (rule == RULE_RISE && cond) |-> fsync_in) else $error("rise rule without high line"); // R6

endmodule

// File: rtl/start_seq_fsm.sv
module start_seq_fsm
    import xfer_start_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_on,
    input  logic             cmd_off,
    input  logic             cmd_reset,
    input  logic             cond,
    input  logic [DLY_W-1:0] delay,
    input  logic             xfer_done,
    output logic             start_strobe,
    output logic             running,
    output logic             busy
);

    seq_state_t       st, st_nxt;
    logic [DLY_W-1:0] cnt, cnt_nxt;
    logic             strobe_q;
    logic             kill;

    assign kill = cmd_off | cmd_reset;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            ST_OFF: begin
                if (cmd_on) st_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (cond) begin
                    if (delay == '0) begin
                        st_nxt = ST_XFER;
                    end else begin
                        st_nxt  = ST_DELAY;
                        cnt_nxt = delay - DLY_W'(1);
                    end
                end
            end
            ST_DELAY: begin
                if (cnt == '0) st_nxt = ST_XFER;
                else           cnt_nxt = cnt - DLY_W'(1);
            end
            ST_XFER: begin
                if (xfer_done) st_nxt = ST_WAIT;
            end
        endcase
        if (kill) st_nxt = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_OFF;
            cnt      <= '0;
            strobe_q <= 1'b0;
        end else begin
            st       <= st_nxt;
            cnt      <= cnt_nxt;
            strobe_q <= (st_nxt == ST_XFER) && (st != ST_XFER);
        end
    end

    always_comb begin
        start_strobe = strobe_q;
        running      = (st != ST_OFF);
        busy         = (st == ST_DELAY) || (st == ST_XFER);
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_strobe |=> !start_strobe) else $error("strobe wider than one cycle"); // R8
    AST_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
        kill |=> !running) else $error("disable did not take effect"); // R1
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !running |-> !start_strobe) else $error("strobe while idle"); // R2
    AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DELAY && !kill) |=> busy) else $error("delay window left early"); // R9
    AST_XFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_XFER && !xfer_done && !kill) |=> (st == ST_XFER && !start_strobe))
        else $error("transfer restarted without done"); // R9

endmodule

// File: rtl/frame_period_gen.sv
module frame_period_gen #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             pulse
);

    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = {period, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt >= last) cnt <= '0;
        else                  cnt <= cnt + CNT_W'(1);
    end

    assign pulse = run && (period != '0) && (cnt == last);

    AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse) else $error("frame pulses adjacent"); // R10

endmodule

// File: rtl/xfer_start_ctrl.sv
module xfer_start_ctrl #(
    parameter int DLY_W = 8,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_on,
    input  logic             cmd_off,
    input  logic             cmd_reset,
    input  logic [3:0]       start_mode,
    input  logic [DLY_W-1:0] start_delay,
    input  logic [PER_W-1:0] period_div,
    input  logic             fsync_in,
    input  logic             peer_start,
    input  logic             cmp_hit,
    input  logic             xfer_done,
    output logic             start_strobe,
    output logic             frame_pulse,
    output logic             running,
    output logic             busy
);

    logic cond;

    start_cond_sel u_cond (
        .clk        (clk),
        .rst        (rst),
        .rule       (start_mode),
        .fsync_in   (fsync_in),
        .peer_start (peer_start),
        .cmp_hit    (cmp_hit),
        .cond       (cond)
    );

    start_seq_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmd_on       (cmd_on),
        .cmd_off      (cmd_off),
        .cmd_reset    (cmd_reset),
        .cond         (cond),
        .delay        (start_delay),
        .xfer_done    (xfer_done),
        .start_strobe (start_strobe),
        .running      (running),
        .busy         (busy)
    );

    frame_period_gen #(.PER_W(PER_W)) u_period (
        .clk    (clk),
        .rst    (rst),
        .run    (running),
        .period (period_div),
        .pulse  (frame_pulse)
    );

    AST_UNDEF_RULE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (start_mode > 4'd8 && !busy) |=> !start_strobe) else $error("undefined rule started"); // R7

endmodule

// File: tb/test_xfer_start_ctrl.sv
module test_xfer_start_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_on, cmd_off, cmd_reset;
    logic [3:0] start_mode;
    logic [7:0] start_delay, period_div;
    logic       fsync_in, peer_start, cmp_hit, xfer_done;
    logic       start_strobe, frame_pulse, running, busy;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    xfer_start_ctrl i_xfer_start_ctrl (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmd_off(cmd_off), .cmd_reset(cmd_reset),
        .start_mode(start_mode), .start_delay(start_delay), .period_div(period_div),
        .fsync_in(fsync_in), .peer_start(peer_start), .cmp_hit(cmp_hit), .xfer_done(xfer_done),
        .start_strobe(start_strobe), .frame_pulse(frame_pulse), .running(running), .busy(busy)
    );

    // fields: mode[16:13] delay[12:5] init[4] trig[3] peer[2] cmp[1] hit[0]
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {4'd1,  8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd8,  8'd3,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'd1,  8'd2,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'd2,  8'd1,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'd3,  8'd4,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd4,  8'd2,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'd4,  8'd2,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd5,  8'd5,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd5,  8'd1,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd6,  8'd0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {4'd7,  8'd7,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd9,  8'd0,   1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'd15, 8'd2,   1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd3,  8'd255, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string rule_tag(input logic [3:0] m);
        if (m == 4'd0) return "R3";
        if (m == 4'd1 || m == 4'd8) return "R4";
        if (m == 4'd2 || m == 4'd3) return "R5";
        if (m >= 4'd4 && m <= 4'd7) return "R6";
        return "R7";
    endfunction

    // Counts negedges after the edge that samples the stimulus; pulses drop after 'hold' cycles.
    task automatic wait_strobe(input int limit, input int hold, output int first, output int count);
        first = -1;
        count = 0;
        for (int n = 0; n < limit; n++) begin
            @(negedge clk);
            if (n == hold - 1) begin
                peer_start = 1'b0; cmp_hit = 1'b0; xfer_done = 1'b0;
                cmd_on = 1'b0; cmd_off = 1'b0; cmd_reset = 1'b0;
            end
            if (start_strobe) begin
                if (first < 0) first = n;
                count++;
            end
        end
    endtask

    task automatic soft_reset();
        @(negedge clk);
        cmd_reset = 1'b1;
        @(negedge clk);
        cmd_reset = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int first, cnt, p1, p2;
        rst = 1'b1; cmd_on = 0; cmd_off = 0; cmd_reset = 0;
        start_mode = 0; start_delay = 0; period_div = 0;
        fsync_in = 0; peer_start = 0; cmp_hit = 0; xfer_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!running && !busy && !start_strobe && !frame_pulse, "R11 reset outputs",
              {running, busy, start_strobe, frame_pulse}, 0);

        // Table walk: each rule, matching and non-matching stimuli, delays
        for (int v = 0; v < NV; v++) begin
            logic [16:0] e;
            e = VEC[v];
            @(negedge clk);
            cmd_reset = 1'b1;
            start_mode = e[16:13]; start_delay = e[12:5]; fsync_in = e[4];
            @(negedge clk);
            cmd_reset = 1'b0; cmd_on = 1'b1;
            @(negedge clk);
            cmd_on = 1'b0;
            wait_strobe(3, 1, first, cnt);
            check(cnt == 0, {rule_tag(e[16:13]), " no start before trigger"}, cnt, 0);
            fsync_in = e[3]; peer_start = e[2]; cmp_hit = e[1];
            wait_strobe(int'(e[12:5]) + 6, 1, first, cnt);
            if (e[0]) begin
                check(first == int'(e[12:5]), {rule_tag(e[16:13]), " R8 strobe latency"},
                      first, int'(e[12:5]));
                check(cnt == 1, {rule_tag(e[16:13]), " R8 single strobe"}, cnt, 1);
            end else begin
                check(cnt == 0, {rule_tag(e[16:13]), " stimulus must not start"}, cnt, 0);
            end
        end

        // R3 free-running start and restart after done
        soft_reset();
        start_mode = 4'd0; start_delay = 8'd2;
        cmd_on = 1'b1;
        wait_strobe(8, 1, first, cnt);
        check(first == 3, "R3 free-running first start", first, 3);
        check(cnt == 1, "R3 one start while transfer open", cnt, 1);
        xfer_done = 1'b1;
        wait_strobe(8, 1, first, cnt);
        check(first == 3, "R3 restart after done", first, 3);

        // R9 trigger held over delay window, then trigger during transfer
        soft_reset();
        start_mode = 4'd1; start_delay = 8'd5;
        cmd_on = 1'b1;
        wait_strobe(2, 1, first, cnt);
        peer_start = 1'b1;
        wait_strobe(15, 3, first, cnt);
        check(first == 5 && cnt == 1, "R9 held trigger gives one strobe", cnt * 100 + first, 105);
        check(busy, "R9 busy during transfer", busy, 1);
        peer_start = 1'b1;
        wait_strobe(10, 1, first, cnt);
        check(cnt == 0, "R9 trigger during transfer ignored", cnt, 0);

        // R2 soft reset cancels pending delay
        soft_reset();
        start_mode = 4'd1; start_delay = 8'd6;
        cmd_on = 1'b1;
        wait_strobe(2, 1, first, cnt);
        peer_start = 1'b1;
        wait_strobe(2, 1, first, cnt);
        cmd_reset = 1'b1;
        wait_strobe(12, 1, first, cnt);
        check(cnt == 0, "R2 reset cancels pending start", cnt, 0);
        check(!running, "R2 idle after soft reset", running, 0);

        // R1 enable/disable, disable wins
        start_mode = 4'd9;
        @(negedge clk);
        cmd_on = 1'b1; cmd_off = 1'b1;
        @(negedge clk);
        cmd_on = 1'b0; cmd_off = 1'b0;
        check(!running, "R1 disable wins over enable", running, 0);
        cmd_on = 1'b1;
        @(negedge clk);
        cmd_on = 1'b0;
        check(running, "R1 enable", running, 1);
        cmd_off = 1'b1;
        @(negedge clk);
        cmd_off = 1'b0;
        check(!running, "R1 disable", running, 0);

        // R10 frame period
        for (int k = 0; k < 3; k++) begin
            int pv;
            pv = (k == 0) ? 2 : ((k == 1) ? 1 : 0);
            soft_reset();
            start_mode = 4'd9; period_div = 8'(pv);
            cmd_on = 1'b1;
            p1 = -1; p2 = -1;
            for (int n = 0; n < 40; n++) begin
                @(negedge clk);
                cmd_on = 1'b0;
                if (frame_pulse) begin
                    if (p1 < 0) p1 = n;
                    else if (p2 < 0) p2 = n;
                end
            end
            if (pv == 0) begin
                check(p1 < 0, "R10 no pulse with zero period", p1, -1);
            end else begin
                check(p1 == 2 * pv + 1, "R10 first pulse position", p1, 2 * pv + 1);
                check(p2 - p1 == 2 * (pv + 1), "R10 pulse spacing", p2 - p1, 2 * (pv + 1));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule